// File: doc/BRIEF.md
# Lockable System Control Register Bank

This block is a small bank of control and status registers reached over a plain 32-bit register bus. The bus carries a valid strobe, a write qualifier, a byte address, write data and read data. Software uses the bank to keep two sets of sticky flag bits and to read the state of a removable card slot. It can also sample a free-running reference tick count and request a board-level reset. The reset request only takes effect after a protection key has been written to the lock register.

Each flag set has one address that ORs bits in and a second address that clears bits. No read-modify-write is needed. Clock-generator, DMA-routing and peripheral-select locations are reserved: they read as zero and ignore writes. Any other address is undecoded. It reads as zero and raises a one-cycle error pulse.

The `VARIANT` parameter picks the board generation. It moves the card write-protect bit. On the newest generation it also removes the reset control register.

Top module: `sysctl_bank`

## Requirements
- R1: After reset the lock register holds 0, both flag registers and the stored reset level are 0, read data is 0 and no reset request or error is signalled. A read of offset 0x20 then returns 0x0001_0000.
- R2: A write to offset 0x20 of exactly 0xA05F stores that value; any other value stores its bits 14:0 with bit 15 forced to 0. A read of 0x20 returns the stored 16-bit value in bits 15:0 and, in bit 16, a 1 when the stored value is not 0xA05F.
- R3: A write to 0x30 ORs the data into the volatile flags, a write to 0x34 clears the flags whose data bits are 1; a read of 0x30 returns the flags and a read of 0x34 returns 0.
- R4: The non-volatile flags behave as in R3 with set/read at 0x38 and clear at 0x3C (0x3C reads 0), independently of the volatile flags.
- R5: A write to 0x40 while the lock holds 0xA05F stores data bits RL_W-1:0 as the reset level (read back at 0x40) and pulses `rst_req` high for exactly the one cycle after the write. While locked such a write changes nothing and gives no pulse.
- R6: With VARIANT 4 (newest), offset 0x40 reads 0 and writes to it neither store nor pulse `rst_req`, locked or not.
- R7: Offset 0x5C reads a 32-bit count that rises by one every TICK_DIV clock cycles.
- R8: Offset 0x48 reads the card status: bit 0 is `card_present`, `card_wp` sits at bit 2 for VARIANT 0 and 1 and at bit 1 for later variants, all other bits 0.
- R9: Offsets 0x0C-0x1C, 0x64-0x9C and 0xC0-0xD0 (word aligned) read 0, ignore writes and raise no error.
- R10: An access to any other offset, or to an address whose two low bits are not 0, reads 0 and drives `bus_err` high for the single cycle after the access.
- R11: `bus_rdata` is registered: it changes only in the cycle after a read access and holds its value through writes and idle cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_valid | input | 1 | Access strobe, one access per cycle |
| bus_write | input | 1 | 1 = write access, 0 = read access |
| bus_addr | input | ADDR_W | Byte offset of the access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| bus_err | output | 1 | One-cycle pulse after an undecoded access |
| card_wp | input | 1 | Card write-protect level |
| card_present | input | 1 | Card-present level |
| rst_req | output | 1 | One-cycle system reset request |

## Verification
The bound checker watches properties that hold on every cycle. It confirms that `rst_req` is never wider than one cycle and only follows a write to the reset control offset made while the key is held. It also checks that the newest variant never requests reset, that a stored lock value other than the key always has bit 15 clear, that the tick count never jumps, and that `bus_err` and changes on `bus_rdata` only follow an access. The decoded values themselves can only be shown by bench scenarios. These are the OR/clear arithmetic on both flag sets, the lock read format, the write-protect bit position per variant, the reserved ranges reading zero, and the tick rate. The bench compares each read with its own register model over random and directed traffic.

// File: rtl/sysctl_pkg.sv
package sysctl_pkg;

    localparam int          DATA_W       = 32;
    localparam int          OFF_W        = 12;
    localparam logic [15:0] UNLOCK_KEY   = 16'hA05F;
    localparam int          VARIANT_LAST = 4;

    localparam logic [OFF_W-1:0] OFF_LOCK   = 12'h020;
    localparam logic [OFF_W-1:0] OFF_FSET   = 12'h030;
    localparam logic [OFF_W-1:0] OFF_FCLR   = 12'h034;
    localparam logic [OFF_W-1:0] OFF_NSET   = 12'h038;
    localparam logic [OFF_W-1:0] OFF_NCLR   = 12'h03C;
    localparam logic [OFF_W-1:0] OFF_RSTCTL = 12'h040;
    localparam logic [OFF_W-1:0] OFF_CARD   = 12'h048;
    localparam logic [OFF_W-1:0] OFF_TICK   = 12'h05C;

    typedef enum logic [3:0] {
        RG_NONE,
        RG_LOCK,
        RG_FSET,
        RG_FCLR,
        RG_NSET,
        RG_NCLR,
        RG_RST,
        RG_CARD,
        RG_TICK,
        RG_RAZ
    } reg_sel_e;

    typedef struct packed {
        logic     rd;
        logic     wr;
        reg_sel_e sel;
    } access_t;

    function automatic logic in_span(input logic [OFF_W-1:0] off,
                                     input logic [OFF_W-1:0] lo,
                                     input logic [OFF_W-1:0] hi);
        return (off >= lo) && (off <= hi);
    endfunction

    function automatic reg_sel_e decode_offset(input logic [OFF_W-1:0] off,
                                               input logic newest);
        reg_sel_e s;
        if (off[1:0] != 2'b00) begin
            s = RG_NONE;
        end else begin
            case (off)
                OFF_LOCK:   s = RG_LOCK;
                OFF_FSET:   s = RG_FSET;
                OFF_FCLR:   s = RG_FCLR;
                OFF_NSET:   s = RG_NSET;
                OFF_NCLR:   s = RG_NCLR;
                OFF_RSTCTL: s = newest ? RG_RAZ : RG_RST;
                OFF_CARD:   s = RG_CARD;
                OFF_TICK:   s = RG_TICK;
                default: begin
                    if (in_span(off, 12'h00C, 12'h01C) ||
                        in_span(off, 12'h064, 12'h09C) ||
                        in_span(off, 12'h0C0, 12'h0D0))
                        s = RG_RAZ;
                    else
                        s = RG_NONE;
                end
            endcase
        end
        return s;
    endfunction

    function automatic int wp_bit_pos(input int variant);
        return (variant < 2) ? 2 : 1;
    endfunction

endpackage

// File: rtl/sysctl_decode.sv
module sysctl_decode
    import sysctl_pkg::*;
#(
    parameter int ADDR_W  = 12,
    parameter int VARIANT = 2
) (
    input  logic              valid,
    input  logic              write,
    input  logic [ADDR_W-1:0] addr,
    output access_t           acc
);
    localparam logic NEWEST = (VARIANT >= VARIANT_LAST);

    logic             hi_zero;
    logic [OFF_W-1:0] low_off;

    generate
        if (ADDR_W > OFF_W) begin : g_wide
            assign hi_zero = ~|addr[ADDR_W-1:OFF_W];
            assign low_off = addr[OFF_W-1:0];
        end else begin : g_narrow
            assign hi_zero = 1'b1;
            assign low_off = OFF_W'(addr);
        end
    endgenerate

    always_comb begin
        acc.rd  = valid & ~write;
        acc.wr  = valid & write;
        acc.sel = hi_zero ? decode_offset(low_off, NEWEST) : RG_NONE;
    end
endmodule

// File: rtl/sysctl_flagreg.sv
module sysctl_flagreg #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         set_en,
    input  logic         clr_en,
    input  logic [W-1:0] data,
    output logic [W-1:0] q
);
    logic [W-1:0] set_mask;
    logic [W-1:0] clr_mask;

    assign set_mask = set_en ? data : '0;
    assign clr_mask = clr_en ? data : '0;

    always_ff @(posedge clk) begin
        if (rst) q <= '0;
        else     q <= (q | set_mask) & ~clr_mask;
    end
endmodule

// File: rtl/sysctl_tick.sv
module sysctl_tick #(
    parameter int DIV = 5,
    parameter int W   = 32
) (
    input  logic         clk,
    input  logic         rst,
    output logic [W-1:0] count
);
    localparam int PW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [PW-1:0] LAST = PW'(DIV - 1);

    logic [PW-1:0] pre_q;
    logic          wrap;

    assign wrap = (pre_q == LAST);

    always_ff @(posedge clk) begin
        if (rst) begin
            pre_q <= '0;
            count <= '0;
        end else begin
            pre_q <= wrap ? '0 : pre_q + 1'b1;
            if (wrap) count <= count + 1'b1;
        end
    end
endmodule

// File: rtl/sysctl_bank.sv
module sysctl_bank
    import sysctl_pkg::*;
#(
    parameter int ADDR_W   = 12,
    parameter int VARIANT  = 2,
    parameter int TICK_DIV = 5,
    parameter int RL_W     = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_valid,
    input  logic              bus_write,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              bus_err,
    input  logic              card_wp,
    input  logic              card_present,
    output logic              rst_req
);
    localparam int WP_POS = wp_bit_pos(VARIANT);

    access_t            acc;
    logic [15:0]        lock_q;
    logic               unlocked;
    logic [RL_W-1:0]    rstlvl_q;
    logic [1:0][DATA_W-1:0] flag_q;
    logic [DATA_W-1:0]  tick_count;
    logic [DATA_W-1:0]  card_vec;
    logic [DATA_W-1:0]  rd_mux;
    logic               rst_accept;

    sysctl_decode #(.ADDR_W(ADDR_W), .VARIANT(VARIANT)) u_dec (
        .valid (bus_valid),
        .write (bus_write),
        .addr  (bus_addr),
        .acc   (acc)
    );

    sysctl_tick #(.DIV(TICK_DIV), .W(DATA_W)) u_tick (
        .clk   (clk),
        .rst   (rst),
        .count (tick_count)
    );

    // index 0: volatile flags, index 1: non-volatile flags
    generate
        for (genvar g = 0; g < 2; g++) begin : g_flags
            localparam reg_sel_e SET_SEL = (g == 0) ? RG_FSET : RG_NSET;
            localparam reg_sel_e CLR_SEL = (g == 0) ? RG_FCLR : RG_NCLR;
            sysctl_flagreg #(.W(DATA_W)) u_flag (
                .clk    (clk),
                .rst    (rst),
                .set_en (acc.wr && acc.sel == SET_SEL),
                .clr_en (acc.wr && acc.sel == CLR_SEL),
                .data   (bus_wdata),
                .q      (flag_q[g])
            );
        end
    endgenerate

    assign unlocked   = (lock_q == UNLOCK_KEY);
    assign rst_accept = acc.wr && (acc.sel == RG_RST) && unlocked;

    always_comb begin
        card_vec         = '0;
        card_vec[0]      = card_present;
        card_vec[WP_POS] = card_wp;
    end

    always_comb begin
        case (acc.sel)
            RG_LOCK: rd_mux = {15'd0, ~unlocked, lock_q};
            RG_FSET: rd_mux = flag_q[0];
            RG_NSET: rd_mux = flag_q[1];
            RG_RST:  rd_mux = DATA_W'(rstlvl_q);
            RG_CARD: rd_mux = card_vec;
            RG_TICK: rd_mux = tick_count;
            default: rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            lock_q    <= '0;
            rstlvl_q  <= '0;
            bus_rdata <= '0;
            bus_err   <= 1'b0;
            rst_req   <= 1'b0;
        end else begin
            if (acc.wr && acc.sel == RG_LOCK) begin
                if (bus_wdata[15:0] == UNLOCK_KEY) lock_q <= UNLOCK_KEY;
                else                               lock_q <= {1'b0, bus_wdata[14:0]};
            end
            if (rst_accept) rstlvl_q <= bus_wdata[RL_W-1:0];
            rst_req <= rst_accept;
            if (acc.rd) bus_rdata <= rd_mux;
            bus_err <= (acc.rd || acc.wr) && (acc.sel == RG_NONE);
        end
    end
endmodule

// File: rtl/sysctl_bank_chk.sv
module sysctl_bank_chk
    import sysctl_pkg::*;
#(
    parameter int ADDR_W  = 12,
    parameter int VARIANT = 2
) (
    input logic              clk,
    input logic              rst,
    input logic              bus_valid,
    input logic              bus_write,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [31:0]       bus_rdata,
    input logic              bus_err,
    input logic              rst_req,
    input logic [15:0]       lock_q,
    input logic [31:0]       tick_q
);
    localparam logic [ADDR_W-1:0] RST_ADDR = ADDR_W'(OFF_RSTCTL);

    a_r5_single_pulse: assert property (@(posedge clk) disable iff (rst)
        rst_req |=> !rst_req);

    a_r5_req_needs_key: assert property (@(posedge clk) disable iff (rst)
        rst_req |-> $past(bus_valid && bus_write && bus_addr == RST_ADDR
                          && lock_q == UNLOCK_KEY));

    a_r2_locked_bit15_clear: assert property (@(posedge clk) disable iff (rst)
        (lock_q != UNLOCK_KEY) |-> !lock_q[15]);

    a_r7_tick_step: assert property (@(posedge clk) disable iff (rst)
        (tick_q != $past(tick_q)) |-> (tick_q == $past(tick_q) + 32'd1));

    a_r10_err_after_access: assert property (@(posedge clk) disable iff (rst)
        bus_err |-> $past(bus_valid));

    a_r11_rdata_hold: assert property (@(posedge clk) disable iff (rst)
        !($past(bus_valid) && !$past(bus_write)) |-> $stable(bus_rdata));

    generate
        if (VARIANT >= VARIANT_LAST) begin : g_newest
            a_r6_no_request: assert property (@(posedge clk) disable iff (rst)
                !rst_req);
        end
    endgenerate
endmodule

bind sysctl_bank sysctl_bank_chk #(.ADDR_W(ADDR_W), .VARIANT(VARIANT)) chk_i (
    .clk       (clk),
    .rst       (rst),
    .bus_valid (bus_valid),
    .bus_write (bus_write),
    .bus_addr  (bus_addr),
    .bus_rdata (bus_rdata),
    .bus_err   (bus_err),
    .rst_req   (rst_req),
    .lock_q    (lock_q),
    .tick_q    (tick_count)
);

// File: tb/sysctl_bank_tb_top.sv
module sysctl_bank_tb_top;
    localparam int AW  = 12;
    localparam int DIV = 5;
    localparam logic [15:0] KEY = 16'hA05F;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          valid = 1'b0;
    logic          write = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [31:0]   wdata = '0;
    logic          wp = 1'b0;
    logic          present = 1'b0;

    logic [31:0] rd_m, rd_o, rd_n;
    logic        er_m, er_o, er_n;
    logic        rq_m, rq_o, rq_n;

    logic [31:0] s_rd_m, s_rd_o, s_rd_n;
    logic        s_er_m, s_rq_m, s_rq_n;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    logic [15:0] m_lock;
    logic [31:0] m_flag, m_nv;
    logic [7:0]  m_lvl;

    always #4 clk = ~clk;

    sysctl_bank #(.ADDR_W(AW), .VARIANT(2), .TICK_DIV(DIV), .RL_W(8)) dut_i (
        .clk(clk), .rst(rst), .bus_valid(valid), .bus_write(write), .bus_addr(addr),
        .bus_wdata(wdata), .bus_rdata(rd_m), .bus_err(er_m), .card_wp(wp),
        .card_present(present), .rst_req(rq_m));

    sysctl_bank #(.ADDR_W(AW), .VARIANT(0), .TICK_DIV(DIV), .RL_W(8)) dut_old_i (
        .clk(clk), .rst(rst), .bus_valid(valid), .bus_write(write), .bus_addr(addr),
        .bus_wdata(wdata), .bus_rdata(rd_o), .bus_err(er_o), .card_wp(wp),
        .card_present(present), .rst_req(rq_o));

    sysctl_bank #(.ADDR_W(AW), .VARIANT(4), .TICK_DIV(DIV), .RL_W(8)) dut_new_i (
        .clk(clk), .rst(rst), .bus_valid(valid), .bus_write(write), .bus_addr(addr),
        .bus_wdata(wdata), .bus_rdata(rd_n), .bus_err(er_n), .card_wp(wp),
        .card_present(present), .rst_req(rq_n));

    function automatic logic [15:0] lock_next(input logic [31:0] d);
        return (d[15:0] == KEY) ? KEY : {1'b0, d[14:0]};
    endfunction

    function automatic logic [31:0] lock_view(input logic [15:0] l);
        return {15'd0, (l != KEY), l};
    endfunction

    function automatic logic [31:0] flag_next(input logic [31:0] old,
                                              input logic [31:0] d,
                                              input bit is_set);
        return is_set ? (old | d) : (old & ~d);
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
        end
    endtask

    task automatic bus(input bit wr, input logic [AW-1:0] a, input logic [31:0] d);
        @(negedge clk);
        valid = 1'b1; write = wr; addr = a; wdata = d;
        @(posedge clk);
        #1;
        s_rd_m = rd_m; s_rd_o = rd_o; s_rd_n = rd_n;
        s_er_m = er_m; s_rq_m = rq_m; s_rq_n = rq_n;
        @(negedge clk);
        valid = 1'b0; write = 1'b0;
    endtask

    // model-tracking write on the main instance
    task automatic mwrite(input logic [AW-1:0] a, input logic [31:0] d);
        bit exp_pulse;
        exp_pulse = 0;
        bus(1, a, d);
        case (a)
            12'h020: m_lock = lock_next(d);
            12'h030: m_flag = flag_next(m_flag, d, 1);
            12'h034: m_flag = flag_next(m_flag, d, 0);
            12'h038: m_nv   = flag_next(m_nv, d, 1);
            12'h03C: m_nv   = flag_next(m_nv, d, 0);
            12'h040: if (m_lock == KEY) begin m_lvl = d[7:0]; exp_pulse = 1; end
            default: ;
        endcase
        if (a == 12'h040) begin
            check("R5 rst_req after reset-control write", 32'(s_rq_m), 32'(exp_pulse));
            check("R6 newest variant rst_req", 32'(s_rq_n), 32'd0);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] t0, hold;
        void'($urandom(32'd20240611));
        m_lock = '0; m_flag = '0; m_nv = '0; m_lvl = '0;
        repeat (4) @(posedge clk);
        @(negedge clk) rst = 1'b0;
        #1;
        check("R1 rdata after reset", rd_m, 32'd0);
        check("R1 err after reset", 32'(er_m), 32'd0);
        check("R1 rst_req after reset", 32'(rq_m), 32'd0);
        bus(0, 12'h020, 0); check("R1 lock read after reset", s_rd_m, 32'h0001_0000);
        bus(0, 12'h030, 0); check("R1 flags after reset", s_rd_m, 32'd0);
        bus(0, 12'h038, 0); check("R1 nvflags after reset", s_rd_m, 32'd0);
        bus(0, 12'h040, 0); check("R1 reset level after reset", s_rd_m, 32'd0);

        // R5 locked write ignored
        mwrite(12'h040, 32'h0000_005A);
        bus(0, 12'h040, 0); check("R5 locked write ignored", s_rd_m, 32'd0);
        // R2 unlock
        mwrite(12'h020, 32'h0000_A05F);
        bus(0, 12'h020, 0); check("R2 key stored", s_rd_m, 32'h0000_A05F);
        mwrite(12'h040, 32'h0000_015A);
        bus(0, 12'h040, 0); check("R5 level stored", s_rd_m, 32'h0000_005A);
        @(negedge clk); check("R5 pulse one cycle", 32'(rq_m), 32'd0);
        bus(0, 12'h040, 0); check("R6 newest reads zero", s_rd_n, 32'd0);
        check("R6 newest no error", 32'(er_n), 32'd0);
        // R2 non-key with bit 15 set
        mwrite(12'h020, 32'h1234_FFFF);
        bus(0, 12'h020, 0); check("R2 bit15 forced low", s_rd_m, 32'h0001_7FFF);
        mwrite(12'h020, 32'h0000_205F);
        bus(0, 12'h020, 0); check("R2 near-key stays locked", s_rd_m, 32'h0001_205F);
        mwrite(12'h040, 32'h0000_00FF);
        bus(0, 12'h040, 0); check("R5 relocked write ignored", s_rd_m, 32'h0000_005A);

        // R3/R4 directed
        mwrite(12'h030, 32'hF0F0_000F);
        mwrite(12'h034, 32'h3000_0005);
        bus(0, 12'h030, 0); check("R3 set then clear", s_rd_m, m_flag);
        bus(0, 12'h034, 0); check("R3 clear address reads zero", s_rd_m, 32'd0);
        mwrite(12'h038, 32'h0000_FF00);
        bus(0, 12'h038, 0); check("R4 nv set", s_rd_m, m_nv);
        bus(0, 12'h030, 0); check("R4 volatile untouched", s_rd_m, m_flag);
        mwrite(12'h03C, 32'h0000_0F00);
        bus(0, 12'h038, 0); check("R4 nv clear", s_rd_m, m_nv);
        bus(0, 12'h03C, 0); check("R4 nv clear address reads zero", s_rd_m, 32'd0);

        // R8 card status
        wp = 1'b1; present = 1'b0;
        bus(0, 12'h048, 0);
        check("R8 wp bit1 later variant", s_rd_m, 32'h2);
        check("R8 wp bit2 old variant", s_rd_o, 32'h4);
        wp = 1'b0; present = 1'b1;
        bus(0, 12'h048, 0);
        check("R8 present bit0", s_rd_m, 32'h1);
        check("R8 present bit0 old", s_rd_o, 32'h1);

        // R9 reserved ranges
        foreach (m_lvl[i]) begin end
        for (int k = 0; k < 3; k++) begin
            logic [AW-1:0] ra;
            ra = (k == 0) ? 12'h010 : (k == 1) ? 12'h070 : 12'h0C8;
            bus(1, ra, 32'hFFFF_FFFF);
            check("R9 reserved write no error", 32'(s_er_m), 32'd0);
            bus(0, ra, 0);
            check("R9 reserved reads zero", s_rd_m, 32'd0);
            check("R9 reserved read no error", 32'(s_er_m), 32'd0);
        end
        bus(0, 12'h030, 0); check("R9 reserved writes left flags", s_rd_m, m_flag);

        // R10 undecoded
        bus(0, 12'h100, 0);
        check("R10 undecoded reads zero", s_rd_m, 32'd0);
        check("R10 undecoded err", 32'(s_er_m), 32'd1);
        @(negedge clk); check("R10 err one cycle", 32'(er_m), 32'd0);
        bus(1, 12'h022, 32'hFFFF_FFFF);
        check("R10 misaligned err", 32'(s_er_m), 32'd1);
        bus(0, 12'h020, 0); check("R10 misaligned write ignored", s_rd_m, lock_view(m_lock));
        check("R10 decoded no err", 32'(s_er_m), 32'd0);

        // R11 hold through write
        hold = s_rd_m;
        mwrite(12'h030, 32'h0000_0100);
        check("R11 rdata held over write", s_rd_m, hold);
        @(negedge clk); check("R11 rdata held idle", rd_m, hold);

        // R7 tick rate
        bus(0, 12'h05C, 0); t0 = s_rd_m;
        repeat (49) @(posedge clk);
        bus(0, 12'h05C, 0); check("R7 ten ticks in 50 cycles", s_rd_m - t0, 32'd10);

        // random traffic (R2 R3 R4 R5)
        for (int n = 0; n < 300; n++) begin
            int op;
            logic [31:0] d;
            op = $urandom_range(0, 6);
            d = $urandom();
            case (op)
                0: mwrite(12'h030, d);
                1: mwrite(12'h034, d);
                2: mwrite(12'h038, d);
                3: mwrite(12'h03C, d);
                4: mwrite(12'h020, ($urandom_range(0, 2) == 0) ? 32'(KEY) : d);
                5: mwrite(12'h040, d);
                default: begin
                    bus(0, 12'h020, 0); check("R2 random lock view", s_rd_m, lock_view(m_lock));
                end
            endcase
            if ((n % 4) == 0) begin
                bus(0, 12'h030, 0); check("R3 random flags", s_rd_m, m_flag);
                bus(0, 12'h038, 0); check("R4 random nvflags", s_rd_m, m_nv);
                bus(0, 12'h040, 0); check("R5 random level", s_rd_m, 32'(m_lvl));
            end
        end

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule